// File: doc/BRIEF.md
# Byte-Wide Table Read Unit

This block copies one byte at a time out of a 16-bit-wide program memory into an 8-bit table latch. The byte address comes from a 21-bit table pointer. The pointer is held as three byte registers: low, high and upper. The low bit of the pointer chooses which half of the addressed memory word is taken. The remaining twenty bits form the word address.

The processor side issues a read command over a valid/ready pair, with a 2-bit code that chooses how the pointer moves around the access. There are four codes: no change, step up after the access, step down after the access, and step up before the access. The unit holds `cmd_ready` low for the whole of a read, so only one read is ever in flight. A `cmd_valid` seen while `cmd_ready` is low is dropped, not queued, so the source must present the command again once `cmd_ready` returns. A one-cycle `done` pulse marks the point where the latch holds the new byte and the pointer has its final value.

A plain register port reads all four byte registers combinationally. It can write them while the unit is idle.

Top module: `tblrd_unit`

## Requirements
- R1: After reset the low, high and upper pointer bytes and the latch all read 0, `cmd_ready` is 1 and `done` is 0.
- R2: Register select codes are 00 low byte (pointer bits 7:0), 01 high byte (bits 15:8), 10 upper byte (bits 20:16) and 11 latch. `reg_rdata` shows the selected register in the same cycle. A write with `reg_we` takes effect at the next clock edge. The upper register stores only `reg_wdata[4:0]` and reads bits 7:5 as 0.
- R3: Mode 00 reads the byte at the pointer and leaves the pointer unchanged.
- R4: Mode 01 reads the byte at the current pointer and then adds 1 to the pointer.
- R5: Mode 10 reads the byte at the current pointer and then subtracts 1 from the pointer.
- R6: Mode 11 first adds 1 to the pointer, then reads the byte at the new pointer value.
- R7: In the cycle after a command is accepted, `mem_rd_en` is 1 and `mem_addr` equals pointer bits 20:1. The memory returns `mem_rdata` one cycle later. Pointer bit 0 = 1 loads `mem_rdata[15:8]` into the latch, and bit 0 = 0 loads `mem_rdata[7:0]`.
- R8: Pointer steps carry or borrow across all three bytes and wrap modulo 2^21. For example, 0x0000FF+1 = 0x000100, 0x1FFFFF+1 = 0, and 0-1 = 0x1FFFFF.
- R9: A command is accepted at a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 in the two cycles after acceptance. In the third cycle after acceptance, `done` is 1 for exactly one cycle and `cmd_ready` is 1 again.
- R10: While a read is in flight, `cmd_valid` and register writes have no effect. A register write in the same cycle as an accepted command is also dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Read command present |
| cmd_ready | output | 1 | Unit idle and able to take a command |
| cmd_mode | input | 2 | Pointer mode: 00 keep, 01 step up after, 10 step down after, 11 step up before |
| done | output | 1 | One-cycle pulse when the latch and pointer are final |
| reg_sel | input | 2 | Register select for read and write |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Selected register contents |
| mem_rd_en | output | 1 | Program memory read strobe |
| mem_addr | output | 20 | Program memory word address |
| mem_rdata | input | 16 | Program memory word, valid the cycle after the strobe |

## Verification
A wrong pointer state shows up in two places. It appears on `mem_addr` in the first cycle after the next accepted command. It also appears in the pointer bytes, which can be read the moment `done` rises. A wrong byte select or a wrong capture cycle leaves a wrong value in the latch, which can be read in the `done` cycle. A control fault shows as `done` arriving off its fixed third-cycle slot, or as a second read starting while the first is in flight. The bench checks each of these at the earliest cycle it can appear. That includes the pointer boundaries where a carry or borrow crosses a byte or wraps the full 21 bits.

// File: rtl/tblrd_pkg.sv
package tblrd_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP     = 2'b00,
    MODE_POST_INC = 2'b01,
    MODE_POST_DEC = 2'b10,
    MODE_PRE_INC  = 2'b11
  } tbl_mode_e;

  typedef enum logic [1:0] {
    SEL_LOW   = 2'b00,
    SEL_HIGH  = 2'b01,
    SEL_UPPER = 2'b10,
    SEL_LATCH = 2'b11
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ISSUE = 2'b01,
    ST_WAIT  = 2'b10
  } tbl_state_e;
endpackage

// File: rtl/tblrd_ctrl.sv
module tblrd_ctrl
  import tblrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_mode,
  output logic       cmd_ready,
  output logic       accept,
  output logic       issue,
  output logic       capture,
  output logic       done,
  output logic       step_en,
  output logic       step_dn
);
  tbl_state_e state_q;
  tbl_mode_e  mode_q;
  logic       done_q;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign issue     = (state_q == ST_ISSUE);
  assign capture   = (state_q == ST_WAIT);
  assign done      = done_q;

  // pre-increment steps at acceptance, post modes step while the word is fetched
  assign step_en = (accept && tbl_mode_e'(cmd_mode) == MODE_PRE_INC) ||
                   (issue && (mode_q == MODE_POST_INC || mode_q == MODE_POST_DEC));
  assign step_dn = issue && (mode_q == MODE_POST_DEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_KEEP;
      done_q  <= 1'b0;
    end else begin
      done_q <= capture;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_ISSUE;
          mode_q  <= tbl_mode_e'(cmd_mode);
        end
        ST_ISSUE: state_q <= ST_WAIT;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_issues_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (issue && !cmd_ready));
  assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (done && cmd_ready));
endmodule

// File: rtl/tblrd_ptr.sv
module tblrd_ptr
  import tblrd_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [7:0]       wr_data,
  input  logic             step_en,
  input  logic             step_dn,
  output logic [PTR_W-1:0] ptr
);
  localparam int UB = PTR_W - 16;

  logic [PTR_W-1:0] ptr_q;
  assign ptr = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (step_en) begin
      ptr_q <= step_dn ? ptr_q - PTR_W'(1) : ptr_q + PTR_W'(1);
    end else if (wr_en) begin
      unique case (reg_sel_e'(wr_sel))
        SEL_LOW:   ptr_q[7:0]         <= wr_data;
        SEL_HIGH:  ptr_q[15:8]        <= wr_data;
        SEL_UPPER: ptr_q[PTR_W-1:16]  <= wr_data[UB-1:0];
        default:   ;
      endcase
    end
  end

  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !step_en) |=> $stable(ptr_q));
  assert_ptr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && step_en));
endmodule

// File: rtl/tblrd_latch.sv
module tblrd_latch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              sel_bit,
  input  logic              capture,
  input  logic [WORD_W-1:0] word,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        latch
);
  logic       sel_q;
  logic [7:0] latch_q;
  logic [7:0] pick;

  assign pick  = word[{sel_q, 3'b000} +: 8];
  assign latch = latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      latch_q <= '0;
    end else begin
      if (issue)   sel_q   <= sel_bit;
      if (capture) latch_q <= pick;
      else if (wr_en) latch_q <= wr_data;
    end
  end

  assert_latch_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch_q) |-> $past(capture || wr_en));
endmodule

// File: rtl/tblrd_unit.sv
module tblrd_unit
  import tblrd_pkg::*;
#(
  parameter int PTR_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_mode,
  output logic             done,
  input  logic [1:0]       reg_sel,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             mem_rd_en,
  output logic [PTR_W-2:0] mem_addr,
  input  logic [15:0]      mem_rdata
);
  localparam int UB = PTR_W - 16;

  logic accept, issue, capture, step_en, step_dn;
  logic wr_ok, ptr_wr, latch_wr;
  logic [PTR_W-1:0] ptr;
  logic [7:0] latch;

  assign wr_ok    = reg_we && cmd_ready && !accept;
  assign ptr_wr   = wr_ok && (reg_sel_e'(reg_sel) != SEL_LATCH);
  assign latch_wr = wr_ok && (reg_sel_e'(reg_sel) == SEL_LATCH);

  tblrd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_ready(cmd_ready), .accept(accept), .issue(issue), .capture(capture),
    .done(done), .step_en(step_en), .step_dn(step_dn)
  );

  tblrd_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wr_sel(reg_sel),
    .wr_data(reg_wdata), .step_en(step_en), .step_dn(step_dn), .ptr(ptr)
  );

  tblrd_latch #(.WORD_W(16)) u_latch (
    .clk(clk), .rst_n(rst_n), .issue(issue), .sel_bit(ptr[0]),
    .capture(capture), .word(mem_rdata), .wr_en(latch_wr),
    .wr_data(reg_wdata), .latch(latch)
  );

  assign mem_rd_en = issue;
  assign mem_addr  = ptr[PTR_W-1:1];

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_LOW:   reg_rdata = ptr[7:0];
      SEL_HIGH:  reg_rdata = ptr[15:8];
      SEL_UPPER: reg_rdata = {{(8-UB){1'b0}}, ptr[PTR_W-1:16]};
      default:   reg_rdata = latch;
    endcase
  end

  assert_one_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);
endmodule

// File: tb/tblrd_unit_tb.sv
module tblrd_unit_tb;
  localparam int PERIOD = 10;
  localparam int NVEC = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, done;
  logic [1:0] cmd_mode = 2'b00, reg_sel = 2'b00;
  logic reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic mem_rd_en;
  logic [19:0] mem_addr;
  logic [15:0] mem_rdata = 16'h0000;
  int checks = 0, fails = 0;

  always #(PERIOD/2) clk = ~clk;

  tblrd_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_mode(cmd_mode), .done(done), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] mem_word(input logic [19:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] + {4'h0, a[19:16]} + 8'h11};
  endfunction

  function automatic logic [7:0] exp_byte(input logic [20:0] p);
    logic [15:0] w;
    w = mem_word(p[20:1]);
    return p[0] ? w[15:8] : w[7:0];
  endfunction

  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_word(mem_addr);

  // {start pointer, mode, expected pointer after the read}
  localparam logic [43:0] VEC [NVEC] = '{
    {21'h000000, 2'b00, 21'h000000},  // R3
    {21'h012345, 2'b00, 21'h012345},  // R3
    {21'h000001, 2'b01, 21'h000002},  // R4
    {21'h0000FF, 2'b01, 21'h000100},  // R4 R8
    {21'h1FFFFF, 2'b01, 21'h000000},  // R4 R8
    {21'h000000, 2'b10, 21'h1FFFFF},  // R5 R8
    {21'h010000, 2'b10, 21'h00FFFF},  // R5 R8
    {21'h000010, 2'b11, 21'h000011},  // R6
    {21'h00FFFF, 2'b11, 21'h010000},  // R6 R8
    {21'h1FFFFF, 2'b11, 21'h000000}   // R6 R8
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] s, output logic [7:0] d);
    reg_sel = s; #1; d = reg_rdata;
  endtask

  task automatic read_ptr(output logic [20:0] p);
    logic [7:0] l, h, u;
    read_reg(2'b00, l); read_reg(2'b01, h); read_reg(2'b10, u);
    p = {u[4:0], h, l};
  endtask

  task automatic set_ptr(input logic [20:0] p);
    write_reg(2'b00, p[7:0]); write_reg(2'b01, p[15:8]);
    write_reg(2'b10, {3'b000, p[20:16]});
  endtask

  // drive a command, check the address cycle and the done slot (R7, R9)
  task automatic run_cmd(input logic [1:0] m, input logic [20:0] acc, input string req);
    @(negedge clk); cmd_valid = 1'b1; cmd_mode = m;
    @(posedge clk);
    @(negedge clk); cmd_valid = 1'b0;
    check({req, " R7 rd_en"}, {31'd0, mem_rd_en}, 32'd1);
    check({req, " R7 addr"}, {12'd0, mem_addr}, {12'd0, acc[20:1]});
    check({req, " R9 busy"}, {31'd0, cmd_ready}, 32'd0);
    @(negedge clk);
    check({req, " R9 early done"}, {31'd0, done}, 32'd0);
    @(negedge clk);
    check({req, " R9 done"}, {31'd0, done}, 32'd1);
    check({req, " R9 ready"}, {31'd0, cmd_ready}, 32'd1);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(PERIOD * 50000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [20:0] p;
    #(PERIOD * 3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    read_ptr(p); check("R1 ptr", {11'd0, p}, 32'd0);
    read_reg(2'b11, d); check("R1 latch", {24'd0, d}, 32'd0);
    check("R1 ready", {31'd0, cmd_ready}, 32'd1);
    check("R1 done", {31'd0, done}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [20:0] sp, ep, acc;
      logic [1:0] m;
      {sp, m, ep} = VEC[i];
      acc = (m == 2'b11) ? ep : sp;
      set_ptr(sp);
      run_cmd(m, acc, $sformatf("vec%0d", i));
      read_reg(2'b11, d);
      check($sformatf("vec%0d R3-mode latch", i), {24'd0, d}, {24'd0, exp_byte(acc)});
      read_ptr(p);
      check($sformatf("vec%0d R8 ptr", i), {11'd0, p}, {11'd0, ep});
    end

    // R2 upper register keeps only five bits; latch writable
    write_reg(2'b10, 8'hFF);
    read_reg(2'b10, d); check("R2 upper", {24'd0, d}, 32'h1F);
    write_reg(2'b11, 8'h5A);
    read_reg(2'b11, d); check("R2 latch", {24'd0, d}, 32'h5A);
    write_reg(2'b01, 8'hA7);
    read_reg(2'b01, d); check("R2 high", {24'd0, d}, 32'hA7);

    // R10 command and writes ignored while busy
    set_ptr(21'h000020);
    @(negedge clk); cmd_valid = 1'b1; cmd_mode = 2'b01;
    @(posedge clk);
    @(negedge clk); cmd_mode = 2'b11; reg_we = 1'b1; reg_sel = 2'b00; reg_wdata = 8'hAA;
    @(negedge clk);
    @(negedge clk); cmd_valid = 1'b0; reg_we = 1'b0;
    check("R10 done", {31'd0, done}, 32'd1);
    read_ptr(p); check("R10 ptr", {11'd0, p}, 32'h21);
    read_reg(2'b11, d); check("R10 latch", {24'd0, d}, {24'd0, exp_byte(21'h20)});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R10 no extra read", {30'd0, done, mem_rd_en}, 32'd0);
    end

    // R10 write in the acceptance cycle is dropped
    @(negedge clk); cmd_valid = 1'b1; cmd_mode = 2'b00;
    reg_we = 1'b1; reg_sel = 2'b01; reg_wdata = 8'h77;
    @(posedge clk);
    @(negedge clk); cmd_valid = 1'b0; reg_we = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R10 accept-cycle done", {31'd0, done}, 32'd1);
    read_ptr(p); check("R10 accept-cycle write", {11'd0, p}, 32'h21);

    // R7 high byte select on odd pointer
    set_ptr(21'h0ABCD5);
    run_cmd(2'b00, 21'h0ABCD5, "odd");
    read_reg(2'b11, d); check("R7 high byte", {24'd0, d}, {24'd0, mem_word(20'h55E6A) >> 8});

    // R1 reset mid-way clears state
    set_ptr(21'h1F0F0F);
    rst_n = 1'b0; #(PERIOD); @(negedge clk); rst_n = 1'b1;
    read_ptr(p); check("R1 re-reset ptr", {11'd0, p}, 32'd0);

    summary();
    $finish;
  end
endmodule